// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers words between a producer clocked by `wclk` and a consumer clocked by `rclk`. The two clocks may be unrelated, or they may be one and the same clock. Each pointer is kept in binary inside its own domain. It crosses to the other domain as a Gray code through a two-flop synchronizer. Each side works out its occupancy from its own pointer and the synchronized copy of the other side's pointer. A write is accepted on a rising `wclk` edge when `wen` is high. A read is accepted on a rising `rclk` edge when `ren` is high.

Two choices are captured while `rst` is high and then held until the next reset. The first is the output timing mode. In standard mode a word waits in memory until a read request presents it. In fall-through mode the oldest word already stands on `rdata`. The second choice is the source of the almost-flag thresholds. Three select codes give a fixed offset. The fourth code makes the first two writes after reset load the almost-empty offset and then the almost-full offset from the data bus.

Each status flag asserts on the very cycle that the occupancy counted in its own domain reaches the boundary. Activity in the far domain only shows after the pointer has passed through the synchronizer, so a flag can take up to two extra clock cycles to deassert.

Top module: `dcf_prog_fifo`

## Requirements
- R1: After reset both pointers sit at location zero and the FIFO holds no data. In standard mode `r_flag`=1 (empty) and `w_flag`=0 (not full). In fall-through mode `r_flag`=0 (no data ready) and `w_flag`=1 (space available). `afull_n`=1. `aempty_n`=0 whenever the empty occupancy is less than or equal to the offset, and an occupancy of 0 always meets that.
- R2: `mode_std` is captured only while `rst` is high: 1 selects standard mode and 0 selects fall-through mode. Changing it after reset has no effect on the flags or on the data timing.
- R3: In standard mode a written word does not reach `rdata` until a read request. A read accepted on a `rclk` edge updates `rdata` on that same edge, and `rdata` then holds until the next accepted read.
- R4: In fall-through mode the oldest stored word is shown on `rdata` with `r_flag`=1 without any read request. It appears at most three `rclk` edges after the write edge. A read accepted on an edge presents the next word after that edge.
- R5: A write while the FIFO is full (1024 words) is ignored. It neither stores data nor changes any flag.
- R6: A read while the FIFO is empty is ignored. In standard mode `rdata` keeps its value and the read pointer does not move.
- R7: `fsel` is captured while `rst` is high. The codes 2'b01, 2'b10 and 2'b11 set both offsets to 8, 16 and 64.
- R8: `aempty_n` (active low) is 0 exactly when the words written and not yet read number no more than the almost-empty offset.
- R9: `afull_n` (active low) is 0 exactly when the free locations (1024 minus the occupancy) number no more than the almost-full offset.
- R10: With `fsel`=2'b00 the first enabled write after reset loads the almost-empty offset from `wdata[9:0]`. The second loads the almost-full offset in the same way. Neither of these writes is stored, and FIFO writes start with the third.
- R11: `w_flag` and `afull_n` follow their own writes on the edge of the write. `r_flag` and `aempty_n` follow their own reads on the edge of the read. A change made by the opposite domain is seen within three edges of the observing clock.
- R12: Words leave in the order they were written, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Master reset, active high, synchronous to each clock |
| mode_std | input | 1 | Mode select captured at reset: 1 standard, 0 fall-through |
| fsel | input | 2 | Offset source captured at reset: 00 parallel load, 01/10/11 give 8/16/64 |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Write data, also carries the offset values during a parallel load |
| ren | input | 1 | Read enable |
| rdata | output | 36 | Read data |
| w_flag | output | 1 | Standard: full. Fall-through: input ready |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| r_flag | output | 1 | Standard: empty. Fall-through: output ready |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
A corrupted pointer or occupancy shows up in several ways at the ports. Words can come out of order. An extra word can appear after the last one written. A read can follow a full write and present data that was never written. An almost-flag can sit at the wrong count. The bench fills and drains the whole 1024-word array with numbered words, so any slip of order shows on the next read. Each threshold is probed on both sides of its boundary. Own-domain flag changes are checked on the cycle right after the edge that caused them. Far-domain changes are checked once three edges have passed. A wrong captured mode or offset shows at the first flag sample after reset, or at the first word written.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    typedef enum logic [1:0] {
        LD_AE  = 2'd0,
        LD_AF  = 2'd1,
        LD_RUN = 2'd2
    } load_st_e;

    function automatic logic [31:0] bin2gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [6:0] default_offset(logic [1:0] sel);
        case (sel)
            2'b01:   return 7'd8;
            2'b10:   return 7'd16;
            2'b11:   return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr.sv
`timescale 1ns/1ps
module dcf_wr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_std,
    input  logic [1:0]    fsel,
    input  logic          wen,
    input  logic [AW-1:0] wlow,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic          w_flag,
    output logic          afull_n,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    import dcf_pkg::*;
    localparam int PW = AW + 1;
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    logic [AW:0] wptr, rptr_s, wcount;
    logic        std_q, full;
    load_st_e    ld;

    assign rptr_s  = PW'(gray2bin(32'(rgray_s)));
    assign wcount  = wptr - rptr_s;
    assign full    = (wcount == DEPTH);
    assign mem_we  = wen && !full && (ld == LD_RUN);
    assign waddr   = wptr[AW-1:0];
    assign w_flag  = std_q ? full : !full;
    assign afull_n = !((DEPTH - wcount) <= {1'b0, af_off});

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            wgray  <= '0;
            std_q  <= mode_std;
            ld     <= (fsel == 2'b00) ? LD_AE : LD_RUN;
            ae_off <= AW'(default_offset(fsel));
            af_off <= AW'(default_offset(fsel));
        end else begin
            if (mem_we) begin
                wptr  <= wptr + 1'b1;
                wgray <= PW'(bin2gray(32'(wptr + 1'b1)));
            end
            case (ld)
                LD_AE: if (wen) begin
                    ae_off <= wlow;
                    ld     <= LD_AF;
                end
                LD_AF: if (wen) begin
                    af_off <= wlow;
                    ld     <= LD_RUN;
                end
                default: ;
            endcase
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (full && wen) |=> $stable(wptr));
    p_wcount_bound_r9: assert property (@(posedge clk) disable iff (rst)
        wcount <= DEPTH);
    p_gray_step_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/dcf_rd.sv
`timescale 1ns/1ps
module dcf_rd #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_std,
    input  logic          ren,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] mem_q,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          r_flag,
    output logic          aempty_n
);
    import dcf_pkg::*;
    localparam int PW = AW + 1;
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    logic [AW:0]   rptr, wptr_s, rcount;
    logic [DW-1:0] rdata_q;
    logic          std_q, empty, rd_ok;

    assign wptr_s   = PW'(gray2bin(32'(wgray_s)));
    assign rcount   = wptr_s - rptr;
    assign empty    = (rcount == '0);
    assign rd_ok    = ren && !empty;
    assign raddr    = rptr[AW-1:0];
    assign rdata    = std_q ? rdata_q : mem_q;
    assign r_flag   = std_q ? empty : !empty;
    assign aempty_n = !(rcount <= {1'b0, ae_off});

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr    <= '0;
            rgray   <= '0;
            std_q   <= mode_std;
            rdata_q <= '0;
        end else if (rd_ok) begin
            rptr  <= rptr + 1'b1;
            rgray <= PW'(bin2gray(32'(rptr + 1'b1)));
            if (std_q) rdata_q <= mem_q;
        end
    end

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && ren) |=> $stable(rptr));
    p_rcount_bound_r8: assert property (@(posedge clk) disable iff (rst)
        rcount <= DEPTH);
    p_sync_step_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wgray_s ^ $past(wgray_s)));
endmodule

// File: rtl/dcf_prog_fifo.sv
`timescale 1ns/1ps
module dcf_prog_fifo #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          mode_std,
    input  logic [1:0]    fsel,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    output logic          w_flag,
    output logic          afull_n,
    output logic          r_flag,
    output logic          aempty_n
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_off, af_off;
    logic          mem_we;
    logic [DW-1:0] mem_q;

    always_ff @(posedge wclk) begin
        if (mem_we) mem[waddr] <= wdata;
    end
    assign mem_q = mem[raddr];

    dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));
    dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));

    dcf_wr #(.AW(AW)) u_wr (
        .clk(wclk), .rst(rst), .mode_std(mode_std), .fsel(fsel),
        .wen(wen), .wlow(wdata[AW-1:0]), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .mem_we(mem_we),
        .w_flag(w_flag), .afull_n(afull_n), .ae_off(ae_off), .af_off(af_off)
    );

    dcf_rd #(.AW(AW), .DW(DW)) u_rd (
        .clk(rclk), .rst(rst), .mode_std(mode_std), .ren(ren),
        .wgray_s(wgray_s), .ae_off(ae_off), .mem_q(mem_q),
        .rgray(rgray), .raddr(raddr), .rdata(rdata),
        .r_flag(r_flag), .aempty_n(aempty_n)
    );
endmodule

// File: tb/test_dcf_prog_fifo.sv
`timescale 1ns/1ps
module test_dcf_prog_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1, mode_std = 1'b1, wen = 1'b0, ren = 1'b0;
    logic [1:0]  fsel = 2'b01;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        w_flag, afull_n, r_flag, aempty_n;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dcf_prog_fifo i_dcf_prog_fifo (
        .wclk(clk), .rclk(clk), .rst(rst), .mode_std(mode_std), .fsel(fsel),
        .wen(wen), .wdata(wdata), .ren(ren), .rdata(rdata),
        .w_flag(w_flag), .afull_n(afull_n), .r_flag(r_flag), .aempty_n(aempty_n)
    );

    function automatic logic [35:0] pat(int n);
        return 36'(n) * 36'd7 + 36'd1;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic std, logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; mode_std = std; fsel = sel; wen = 1'b0; ren = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(logic [35:0] d);
        wen = 1'b1; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic pop();
        ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_std_basic();
        do_reset(1'b1, 2'b01);
        chk("R1 std r_flag", r_flag, 1);
        chk("R1 std w_flag", w_flag, 0);
        chk("R1 afull_n", afull_n, 1);
        chk("R1 aempty_n", aempty_n, 0);
        mode_std = 1'b0;
        @(negedge clk);
        chk("R2 mode held r_flag", r_flag, 1);
        chk("R2 mode held w_flag", w_flag, 0);
        push(36'hA1); push(36'hB2); push(36'hC3);
        settle();
        chk("R3 no read yet rdata", rdata, 0);
        chk("R3 not empty", r_flag, 0);
        pop(); chk("R12 first", rdata, 36'hA1);
        pop(); chk("R12 second", rdata, 36'hB2);
        pop(); chk("R12 third", rdata, 36'hC3);
        chk("R11 empty on read edge", r_flag, 1);
        pop(); chk("R6 read on empty keeps rdata", rdata, 36'hC3);
        push(36'hD4); settle();
        pop(); chk("R6 pointer unmoved", rdata, 36'hD4);
    endtask

    task automatic t_fwft();
        do_reset(1'b0, 2'b01);
        chk("R1 fwft r_flag", r_flag, 0);
        chk("R1 fwft w_flag", w_flag, 1);
        mode_std = 1'b1;
        push(36'h11);
        repeat (2) @(negedge clk);
        chk("R4 word falls through", rdata, 36'h11);
        chk("R4 output ready", r_flag, 1);
        push(36'h22); settle();
        chk("R4 next word waits", rdata, 36'h11);
        pop(); chk("R4 read presents next", rdata, 36'h22);
        pop(); chk("R11 not ready after last read", r_flag, 0);
    endtask

    task automatic t_thresholds();
        int n = 0, bad = 0;
        do_reset(1'b1, 2'b01);
        for (int i = 0; i < 8; i++) begin push(pat(n)); n++; end
        settle();
        chk("R8 aempty at 8 words", aempty_n, 0);
        push(pat(n)); n++;
        chk("R11 aempty deassert lags", aempty_n, 0);
        settle();
        chk("R8 aempty off at 9 words", aempty_n, 1);
        pop();
        chk("R11 aempty exact on read", aempty_n, 0);
        settle();
        while (n - 1 < 1015) begin push(pat(n)); n++; end
        chk("R9 afull off at 9 free", afull_n, 1);
        push(pat(n)); n++;
        chk("R9 afull at 8 free", afull_n, 0);
        while (n - 1 < 1023) begin push(pat(n)); n++; end
        chk("R11 not full at 1023", w_flag, 0);
        push(pat(n)); n++;
        chk("R11 full at 1024", w_flag, 1);
        push(36'hF_FFFF_FFFF);
        chk("R5 still full", w_flag, 1);
        for (int k = 1; k <= 1024; k++) begin
            pop();
            if (rdata !== pat(k)) bad++;
        end
        chk("R12 full drain order", bad, 0);
        settle();
        chk("R5 empty after 1024 reads", r_flag, 1);
        pop();
        chk("R5 dropped word absent", rdata, pat(1024));
    endtask

    task automatic t_default(logic [1:0] sel, int off);
        do_reset(1'b1, sel);
        for (int i = 0; i < off; i++) push(pat(i));
        settle();
        chk($sformatf("R7 aempty at %0d", off), aempty_n, 0);
        push(pat(off)); settle();
        chk($sformatf("R7 aempty off at %0d", off + 1), aempty_n, 1);
    endtask

    task automatic t_parallel();
        do_reset(1'b1, 2'b00);
        push(36'd5);
        push(36'd1000);
        settle();
        chk("R10 loads not stored", r_flag, 1);
        for (int i = 0; i < 5; i++) push(pat(100 + i));
        settle();
        chk("R10 aempty offset 5 at 5", aempty_n, 0);
        push(pat(105)); settle();
        chk("R10 aempty off at 6", aempty_n, 1);
        for (int i = 6; i < 23; i++) push(pat(100 + i));
        chk("R10 afull off at 23 words", afull_n, 1);
        push(pat(123));
        chk("R10 afull offset 1000 at 24", afull_n, 0);
        pop();
        chk("R10 first stored word", rdata, pat(100));
    endtask

    initial begin
        t_std_basic();
        t_fwft();
        t_thresholds();
        t_default(2'b10, 16);
        t_default(2'b11, 64);
        t_parallel();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule